// File: doc/BRIEF.md
# Host Command and Status Port

This block is the host-side face of a LAN controller. It has an 8-bit data bus and no address lines. The host reaches the controller with a chip-select strobe and read and write strobes. A write under chip-select delivers a command byte. A read under chip-select returns one byte of status. Two further acknowledge strobes, one per DMA channel, share the same read and write strobes and carry the data the external DMA controller moves for each channel.

Every command byte the host writes is split into three parts: a 4-bit command code, a channel-select bit and an interrupt-acknowledge bit. The code and channel are folded into one operation number. The block hands it to the execution logic as a single-cycle pulse. When the execution logic reports that an operation has finished, the block raises an interrupt and records an event code. The interrupt stays up until the host acknowledges it.

The host reads status through one port. Each read returns the next of four status registers in a fixed rotation. Strobe combinations that are not allowed are refused and remembered in a sticky error bit. Each DMA channel registers its request output and gives a single-cycle pulse for each data transfer.

Top module: `hostport_top`

## Requirements
- R1: After reset, `intr_o`, `cmd_valid_o`, `bus_oe`, `dreq_o`, `dma_wr_o` and `dma_rd_o` are low, and the first status read returns 8'h00.
- R2: While `cs_n` is high, no command is accepted and no status is driven, whatever `rd_n` and `wr_n` are. A DMA transfer needs its own acknowledge strobe. At most one transfer pulse of any kind occurs in a cycle.
- R3: A write under chip-select (`cs_n`=0, `wr_n`=0, `rd_n`=1) pulses `cmd_valid_o` for exactly one cycle, in the cycle after the write starts. It does not pulse again while the strobes are held. In the command byte, bit 7 is the interrupt acknowledge (`cmd_intack_o`), bit 4 is the channel select (`cmd_chan_o`) and bits 3:0 are the command code.
- R4: `cmd_op_o` equals the command code for codes 0 to 14. Code 14 is the reset command. Code 15 gives operation 16 when the channel bit is 1 and operation 15 when it is 0.
- R5: Successive status reads (`cs_n`=0, `rd_n`=0, `wr_n`=1) return status registers 0, 1, 2, 3, 0, and so on. The pointer advances once per read. Registers 1, 2 and 3 are bytes [7:0], [15:8] and [23:16] of `stat_ext_i`. The byte read appears on `bus_out` with `bus_oe` high from the cycle after the read starts.
- R6: Status register 0 holds the interrupt flag in bit 7, the sticky error flag in bit 6, zero in bits 5:4 and the last completion event code in bits 3:0.
- R7: A `done_i` pulse raises `intr_o`, records `done_evt_i` and sends the rotation pointer back to register 0.
- R8: `intr_o` stays high until a command with bit 7 set, or a reset command, is written. If a completion arrives in the same cycle as the acknowledge, the interrupt stays high.
- R9: An illegal strobe state sets the sticky error bit. Illegal means more than one of `cs_n` and `dack_n` low, or a selected access with both `rd_n` and `wr_n` low. An illegal state causes no command, no DMA pulse and no status read, and it does not advance the rotation pointer.
- R10: The error bit is cleared only by reset or by the reset command.
- R11: With `dack_n[i]` low and `wr_n` low, `dma_wr_o[i]` pulses once and `dma_wdata_o` carries `bus_in`. With `dack_n[i]` low and `rd_n` low, `dma_rd_o[i]` pulses and `bus_out` carries byte i of `dma_rdata_i`. Both channels behave identically.
- R12: `dreq_o[i]` follows `dma_req_i[i]` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select for command and status, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dack_n | input | 2 | DMA acknowledge per channel, active low |
| bus_in | input | 8 | Data bus driven by the host or DMA |
| bus_out | output | 8 | Data returned to the bus |
| bus_oe | output | 1 | Block drives `bus_out` onto the bus |
| cmd_valid_o | output | 1 | One-cycle command pulse to execution logic |
| cmd_op_o | output | 5 | Decoded operation number |
| cmd_chan_o | output | 1 | Channel select from the command byte |
| cmd_intack_o | output | 1 | Interrupt acknowledge bit of the command byte |
| done_i | input | 1 | Operation completed, one-cycle pulse |
| done_evt_i | input | 4 | Event code of the completed operation |
| stat_ext_i | input | 24 | Contents of status registers 1 to 3 |
| intr_o | output | 1 | Interrupt to the host |
| dma_req_i | input | 2 | DMA request from execution logic per channel |
| dreq_o | output | 2 | DMA request to the DMA controller |
| dma_wr_o | output | 2 | One-cycle DMA write pulse per channel |
| dma_rd_o | output | 2 | One-cycle DMA read pulse per channel |
| dma_wdata_o | output | 8 | Byte captured on a DMA write |
| dma_rdata_i | input | 16 | Read byte per channel, channel 0 in [7:0] |

## Verification
Assertions watch every cycle for the following:
- command and DMA pulses that last more than one cycle or occur together;
- an interrupt or error flag that drops without an acknowledge or reset command;
- a rotation pointer that moves on an illegal strobe state;
- a completion that fails to raise the interrupt or to rewind the pointer.

Only the bench scenarios can show that the values are right: the decoded operation for each code and channel, the order of the bytes read from the status rotation, the captured and returned DMA bytes, and that chip-select held high or an overlapping acknowledge leaves every visible output unchanged.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int CH_IDX_W = 4;

    typedef struct packed {
        logic                bad;
        logic                act;
        logic                to_cmd;
        logic [CH_IDX_W-1:0] ch;
        logic                is_rd;
    } acc_t;

    typedef enum logic [4:0] {
        OP_NOP      = 5'd0,
        OP_ADDR_SET = 5'd1,
        OP_CONFIG   = 5'd2,
        OP_MCAST    = 5'd3,
        OP_XMIT     = 5'd4,
        OP_TDR      = 5'd5,
        OP_DUMP     = 5'd6,
        OP_DIAG     = 5'd7,
        OP_RX_ON    = 5'd8,
        OP_NEXT_BUF = 5'd9,
        OP_RX_OFF   = 5'd10,
        OP_RX_STOP  = 5'd11,
        OP_RETX     = 5'd12,
        OP_ABORT    = 5'd13,
        OP_RESET    = 5'd14,
        OP_PTR_REL  = 5'd15,
        OP_PTR_FIX  = 5'd16
    } op_e;

    function automatic op_e op_decode(input logic [3:0] code, input logic chan);
        if (code == 4'd15) return chan ? OP_PTR_FIX : OP_PTR_REL;
        return op_e'({1'b0, code});
    endfunction
endpackage

// File: rtl/hp_strobe_decode.sv
module hp_strobe_decode #(
    parameter int NCH = 2
) (
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [NCH-1:0]   dack_n,
    output hp_pkg::acc_t     acc_o
);
    int nsel;

    always_comb begin
        acc_o = '0;
        nsel  = $countones({~dack_n, ~cs_n});
        if (nsel > 1) begin
            acc_o.bad = 1'b1;
        end else if (nsel == 1) begin
            if (!rd_n && !wr_n) begin
                acc_o.bad = 1'b1;
            end else if (rd_n != wr_n) begin
                acc_o.act    = 1'b1;
                acc_o.is_rd  = !rd_n;
                acc_o.to_cmd = !cs_n;
                for (int i = 0; i < NCH; i++) begin
                    if (!dack_n[i]) acc_o.ch = hp_pkg::CH_IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/hp_dma_chan.sv
module hp_dma_chan #(
    parameter int IDX = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_i,
    input  hp_pkg::acc_t cur_i,
    input  hp_pkg::acc_t prev_i,
    output logic         dreq_o,
    output logic         rd_o,
    output logic         wr_o
);
    typedef struct packed {
        logic dreq;
        logic rd;
        logic wr;
    } chan_st_t;

    chan_st_t d, q;
    logic     hit, fresh;

    always_comb begin
        hit    = cur_i.act && !cur_i.to_cmd && (cur_i.ch == hp_pkg::CH_IDX_W'(IDX));
        fresh  = hit && (cur_i != prev_i);
        d.dreq = req_i;
        d.rd   = fresh && cur_i.is_rd;
        d.wr   = fresh && !cur_i.is_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dreq_o = q.dreq;
    assign rd_o   = q.rd;
    assign wr_o   = q.wr;

    // R11: a data pulse never spans two cycles
    p_wr_single_r11: assert property (@(posedge clk) disable iff (!rst_n) wr_o |=> !wr_o);
    p_rd_single_r11: assert property (@(posedge clk) disable iff (!rst_n) rd_o |=> !rd_o);
    // R12: request output tracks the request input one cycle later
    p_dreq_follow_r12: assert property (@(posedge clk) disable iff (!rst_n) req_i |=> dreq_o);
endmodule

// File: rtl/hp_status_rot.sv
module hp_status_rot #(
    parameter int NSTAT = 4,
    parameter int DW    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_start_i,
    input  logic                  bad_i,
    input  logic                  clear_i,
    input  logic [NSTAT*DW-1:0]   stat_i,
    output logic [DW-1:0]         data_o
);
    localparam int PW = (NSTAT > 1) ? $clog2(NSTAT) : 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [DW-1:0] data;
    } rot_st_t;

    rot_st_t d, q;

    always_comb begin
        d = q;
        if (rd_start_i) begin
            d.data = stat_i[int'(q.ptr)*DW +: DW];
            d.ptr  = (q.ptr == PW'(NSTAT-1)) ? '0 : PW'(q.ptr + 1'b1);
        end
        if (clear_i) d.ptr = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o = q.data;

    // R9: an illegal strobe state leaves the rotation where it was
    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_i && !clear_i) |=> (q.ptr == $past(q.ptr)));
    // R7: a completion or reset command rewinds to register 0
    p_ptr_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (q.ptr == '0));
    // R5: the pointer moves only on a status read
    p_ptr_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_start_i && !clear_i) |=> $stable(q.ptr));
endmodule

// File: rtl/hostport_top.sv
module hostport_top #(
    parameter int DW       = 8,
    parameter int NCH      = 2,
    parameter int NSTAT    = 4,
    parameter int EVW      = 4,
    parameter int ACK_BIT  = 7,
    parameter int CHAN_BIT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   rd_n,
    input  logic                   wr_n,
    input  logic [NCH-1:0]         dack_n,
    input  logic [DW-1:0]          bus_in,
    output logic [DW-1:0]          bus_out,
    output logic                   bus_oe,
    output logic                   cmd_valid_o,
    output logic [4:0]             cmd_op_o,
    output logic                   cmd_chan_o,
    output logic                   cmd_intack_o,
    input  logic                   done_i,
    input  logic [EVW-1:0]         done_evt_i,
    input  logic [(NSTAT-1)*DW-1:0] stat_ext_i,
    output logic                   intr_o,
    input  logic [NCH-1:0]         dma_req_i,
    output logic [NCH-1:0]         dreq_o,
    output logic [NCH-1:0]         dma_wr_o,
    output logic [NCH-1:0]         dma_rd_o,
    output logic [DW-1:0]          dma_wdata_o,
    input  logic [NCH*DW-1:0]      dma_rdata_i
);
    import hp_pkg::*;

    localparam int PADW = DW - 2 - EVW;

    typedef struct packed {
        acc_t           prev;
        logic           cmd_valid;
        logic [4:0]     cmd_op;
        logic           cmd_chan;
        logic           cmd_ack;
        logic           intr;
        logic           err;
        logic [EVW-1:0] evt;
        logic           oe;
        logic           src_stat;
        logic [DW-1:0]  dma_hold;
        logic [DW-1:0]  wdata;
    } top_st_t;

    top_st_t d, q;
    acc_t    cur;
    logic    start, cmd_start, stat_start, dma_rd_start, dma_wr_start, rst_cmd, rot_clear;
    logic [DW-1:0]         stat_rd;
    logic [NSTAT*DW-1:0]   stat_flat;

    hp_strobe_decode #(.NCH(NCH)) u_dec (
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .dack_n(dack_n), .acc_o(cur)
    );

    always_comb begin
        start        = cur.act && (cur != q.prev);
        cmd_start    = start && cur.to_cmd && !cur.is_rd;
        stat_start   = start && cur.to_cmd && cur.is_rd;
        dma_rd_start = start && !cur.to_cmd && cur.is_rd;
        dma_wr_start = start && !cur.to_cmd && !cur.is_rd;
        rst_cmd      = cmd_start && (op_decode(bus_in[3:0], bus_in[CHAN_BIT]) == OP_RESET);
        rot_clear    = done_i || rst_cmd;
        stat_flat    = {stat_ext_i, q.intr, q.err, {PADW{1'b0}}, q.evt};

        d           = q;
        d.prev      = cur;
        d.cmd_valid = 1'b0;
        if (cmd_start) begin
            d.cmd_valid = 1'b1;
            d.cmd_op    = op_decode(bus_in[3:0], bus_in[CHAN_BIT]);
            d.cmd_chan  = bus_in[CHAN_BIT];
            d.cmd_ack   = bus_in[ACK_BIT];
            if (bus_in[ACK_BIT] || rst_cmd) d.intr = 1'b0;
        end
        if (cur.bad) d.err = 1'b1;
        if (rst_cmd) d.err = 1'b0;
        if (done_i) begin
            d.intr = 1'b1;
            d.evt  = done_evt_i;
        end
        d.oe = cur.act && cur.is_rd;
        if (stat_start) d.src_stat = 1'b1;
        if (dma_rd_start) begin
            d.src_stat = 1'b0;
            d.dma_hold = dma_rdata_i[int'(cur.ch)*DW +: DW];
        end
        if (dma_wr_start) d.wdata = bus_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    hp_status_rot #(.NSTAT(NSTAT), .DW(DW)) u_rot (
        .clk(clk), .rst_n(rst_n), .rd_start_i(stat_start), .bad_i(cur.bad),
        .clear_i(rot_clear), .stat_i(stat_flat), .data_o(stat_rd)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        hp_dma_chan #(.IDX(g)) u_chan (
            .clk(clk), .rst_n(rst_n), .req_i(dma_req_i[g]),
            .cur_i(cur), .prev_i(q.prev),
            .dreq_o(dreq_o[g]), .rd_o(dma_rd_o[g]), .wr_o(dma_wr_o[g])
        );
    end

    assign bus_out      = q.src_stat ? stat_rd : q.dma_hold;
    assign bus_oe       = q.oe;
    assign cmd_valid_o  = q.cmd_valid;
    assign cmd_op_o     = q.cmd_op;
    assign cmd_chan_o   = q.cmd_chan;
    assign cmd_intack_o = q.cmd_ack;
    assign intr_o       = q.intr;
    assign dma_wdata_o  = q.wdata;

    // R3: a held write yields a single command pulse
    p_cmd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);
    // R8: interrupt drops only through an acknowledging or reset command
    p_intr_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intr_o) |-> (cmd_valid_o && (cmd_intack_o || cmd_op_o == OP_RESET)));
    // R7: completion raises the interrupt
    p_done_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> intr_o);
    // R10: error flag drops only through the reset command
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.err) |-> (cmd_valid_o && cmd_op_o == OP_RESET));
    // R9: an illegal state produces no transfer
    p_bad_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cur.bad |=> (!cmd_valid_o && dma_wr_o == '0 && dma_rd_o == '0 && !bus_oe));
    // R2: at most one transfer pulse per cycle
    p_one_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid_o, dma_wr_o, dma_rd_o}));
endmodule

// File: tb/hostport_top_tb_top.sv
module hostport_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, rd_n, wr_n;
    logic [1:0]  dack_n;
    logic [7:0]  bus_in;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic        cmd_valid_o;
    logic [4:0]  cmd_op_o;
    logic        cmd_chan_o, cmd_intack_o;
    logic        done_i;
    logic [3:0]  done_evt_i;
    logic [23:0] stat_ext_i;
    logic        intr_o;
    logic [1:0]  dma_req_i, dreq_o, dma_wr_o, dma_rd_o;
    logic [7:0]  dma_wdata_o;
    logic [15:0] dma_rdata_i;

    int nvec = 0;
    int nerr = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hostport_top dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .dack_n(dack_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_chan_o(cmd_chan_o),
        .cmd_intack_o(cmd_intack_o), .done_i(done_i), .done_evt_i(done_evt_i),
        .stat_ext_i(stat_ext_i), .intr_o(intr_o), .dma_req_i(dma_req_i),
        .dreq_o(dreq_o), .dma_wr_o(dma_wr_o), .dma_rd_o(dma_rd_o),
        .dma_wdata_o(dma_wdata_o), .dma_rdata_i(dma_rdata_i)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic bus_idle();
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; dack_n = 2'b11;
    endtask

    task automatic host_write(input logic [7:0] b);
        @(negedge clk);
        bus_in = b; cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1;
        tick();
    endtask

    task automatic end_access();
        bus_idle(); tick();
    endtask

    task automatic host_read(output logic [7:0] v, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
        tick();
        v = bus_out; oe = bus_oe;
        end_access();
    endtask

    task automatic pulse_done(input logic [3:0] e);
        @(negedge clk);
        done_i = 1'b1; done_evt_i = e;
        @(negedge clk);
        done_i = 1'b0;
        tick();
    endtask

    task automatic expect_read(input logic [7:0] exp, input string rq);
        logic [7:0] v; logic oe;
        host_read(v, oe);
        chk(oe && v == exp, rq, {oe, v}, {1'b1, exp});
    endtask

    task automatic t_reset();
        chk(!intr_o && !cmd_valid_o && !bus_oe, "R1 control outputs", {intr_o, cmd_valid_o, bus_oe}, 0);
        chk(dreq_o == 0 && dma_wr_o == 0 && dma_rd_o == 0, "R1 dma outputs", {dreq_o, dma_wr_o, dma_rd_o}, 0);
        expect_read(8'h00, "R1 first status");
    endtask

    task automatic t_rotation();
        pulse_done(4'h5);
        chk(intr_o, "R7 intr raised", intr_o, 1);
        expect_read(8'h85, "R5 R6 reg0");
        expect_read(8'hA1, "R5 reg1");
        expect_read(8'hB2, "R5 reg2");
        expect_read(8'hC3, "R5 reg3");
        expect_read(8'h85, "R5 wrap reg0");
        expect_read(8'hA1, "R5 reg1 again");
        pulse_done(4'h9);
        expect_read(8'h89, "R7 rewind and event");
    endtask

    task automatic t_cmd_decode();
        for (int c = 0; c < 16; c++) begin
            for (int ch = 0; ch < 2; ch++) begin
                logic [4:0] eop;
                eop = (c == 15) ? (ch == 1 ? 5'd16 : 5'd15) : 5'(c);
                host_write(8'((ch << 4) | c));
                chk(cmd_valid_o && cmd_op_o == eop && cmd_chan_o == 1'(ch) && !cmd_intack_o,
                    "R4 R3 decode", {cmd_valid_o, cmd_chan_o, cmd_op_o}, {1'b1, 1'(ch), eop});
                tick();
                chk(!cmd_valid_o, "R3 single pulse", cmd_valid_o, 0);
                end_access();
            end
        end
        host_write(8'h93);
        chk(cmd_valid_o && cmd_intack_o && cmd_chan_o && cmd_op_o == 5'd3, "R3 ack field",
            {cmd_intack_o, cmd_chan_o, cmd_op_o}, {2'b11, 5'd3});
        end_access();
    endtask

    task automatic t_intr();
        host_write(8'h8E); end_access();
        pulse_done(4'h3);
        host_write(8'h00);
        chk(intr_o, "R8 held without ack", intr_o, 1);
        end_access();
        host_write(8'h80);
        chk(!intr_o, "R8 ack clears", intr_o, 0);
        end_access();
        @(negedge clk);
        done_i = 1'b1; done_evt_i = 4'h6;
        bus_in = 8'h80; cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1;
        tick();
        chk(cmd_valid_o && intr_o, "R8 done wins over ack", {cmd_valid_o, intr_o}, 2'b11);
        @(negedge clk); done_i = 1'b0;
        end_access();
        host_write(8'h0E);
        chk(!intr_o, "R8 reset command clears", intr_o, 0);
        end_access();
    endtask

    task automatic t_cs_high();
        host_write(8'h8E); end_access();
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; wr_n = 1'b0; bus_in = 8'h04;
        tick();
        chk(!cmd_valid_o && !bus_oe, "R2 cs high write", {cmd_valid_o, bus_oe}, 0);
        @(negedge clk); wr_n = 1'b1;
        tick();
        chk(!cmd_valid_o && !bus_oe, "R2 cs high read", {cmd_valid_o, bus_oe}, 0);
        end_access();
        pulse_done(4'h1);
        expect_read(8'h81, "R2 no error from cs high");
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
        tick();
        chk(!cmd_valid_o && !bus_oe, "R9 both strobes low", {cmd_valid_o, bus_oe}, 0);
        end_access();
        pulse_done(4'h1);
        expect_read(8'hC1, "R9 error flag set");
    endtask

    task automatic t_overlap();
        host_write(8'h8E); end_access();
        pulse_done(4'h2);
        @(negedge clk);
        cs_n = 1'b0; dack_n = 2'b10; rd_n = 1'b0; wr_n = 1'b1;
        tick();
        chk(!bus_oe && dma_rd_o == 0, "R9 overlap no transfer", {bus_oe, dma_rd_o}, 0);
        end_access();
        expect_read(8'hC2, "R9 pointer not advanced");
        expect_read(8'hA1, "R9 next register");
        host_write(8'h80); end_access();
        pulse_done(4'h2);
        expect_read(8'hC2, "R10 error survives ack");
        host_write(8'h0E); end_access();
        pulse_done(4'h2);
        expect_read(8'h82, "R10 reset command clears error");
    endtask

    task automatic t_dma();
        for (int ch = 0; ch < 2; ch++) begin
            logic [1:0] m;
            logic [7:0] wv, rv;
            m  = 2'(1 << ch);
            wv = 8'h5A ^ 8'(ch);
            rv = (ch == 1) ? 8'h3C : 8'hC3;
            @(negedge clk); dma_req_i = m;
            tick();
            chk(dreq_o == m, "R12 request", dreq_o, m);
            @(negedge clk); dma_req_i = 2'b00;
            tick();
            chk(dreq_o == 0, "R12 request drop", dreq_o, 0);
            @(negedge clk);
            dack_n = ~m; wr_n = 1'b0; rd_n = 1'b1; bus_in = wv;
            tick();
            chk(dma_wr_o == m && dma_wdata_o == wv && !cmd_valid_o, "R11 dma write",
                {dma_wr_o, dma_wdata_o}, {m, wv});
            tick();
            chk(dma_wr_o == 0, "R11 write pulse ends", dma_wr_o, 0);
            end_access();
            @(negedge clk);
            dack_n = ~m; rd_n = 1'b0; wr_n = 1'b1;
            tick();
            chk(bus_oe && bus_out == rv && dma_rd_o == m, "R11 dma read",
                {bus_oe, dma_rd_o, bus_out}, {1'b1, m, rv});
            end_access();
        end
    endtask

    initial begin
        rst_n = 1'b0;
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; dack_n = 2'b11;
        bus_in = 8'h00; done_i = 1'b0; done_evt_i = 4'h0;
        stat_ext_i = 24'hC3B2A1; dma_req_i = 2'b00; dma_rdata_i = 16'h3CC3;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        tick();
        t_reset();
        t_rotation();
        t_cmd_decode();
        t_intr();
        t_cs_high();
        t_overlap();
        t_dma();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nvec++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule